// File: doc/BRIEF.md
# Operand Address Resolver

This block turns the operand part of an instruction into a resolved value. A caller presents an addressing mode, a 12-bit field that is either a constant or an address, and a register number, and pulses `start`. The block reads the named register through a combinational register-file port. When the mode needs memory, it reads a 4096-word synchronous memory once or twice, and that memory returns data one cycle after each request. When the work is finished it pulses `done` for one cycle. In the same cycle it presents the operand value, the effective address and a flag that says whether an effective address exists.

A three-state machine does the sequencing. `ST_IDLE` accepts a request. `ST_FIRST` waits for the first memory word. `ST_CHAIN` waits for the second word, which only the memory-indirect mode needs. The transitions are as follows:
- A start in `ST_IDLE` for a mode that needs no memory finishes in place.
- A start in `ST_IDLE` for a memory mode moves to `ST_FIRST`.
- `ST_FIRST` returns to `ST_IDLE` for a single-read mode and moves to `ST_CHAIN` for memory indirect.
- `ST_CHAIN` always returns to `ST_IDLE`.

The visible results change only when `done` pulses.

Top module: `ea_unit`

## Requirements
- R1: After reset, `done`, `busy` and `ea_valid` are low, and `operand` and `ea` are zero.
- R2: Mode code 0 (immediate) gives `done` in the cycle after the start cycle. `operand` is the 12-bit field zero-extended to 16 bits, `ea_valid` is 0, `ea` is 0, and no memory read is issued.
- R3: Mode code 2 (register) gives `done` in the cycle after start. `operand` is the full 16-bit content of the selected register, `ea_valid` is 0, `ea` is 0, and no memory read is issued.
- R4: Mode code 1 (direct) issues one read at the field address in the start cycle. `done` follows two cycles after start, with `ea` equal to the field and `operand` equal to the memory word at that address.
- R5: Mode code 3 (memory indirect) issues two reads. The low 12 bits of the word at the field address are the effective address, `operand` is the word at that effective address, and `done` comes three cycles after start.
- R6: Mode code 4 (indexed) uses the effective address (field + low 12 bits of the register) modulo 4096. It makes one read and gives `done` two cycles after start.
- R7: Mode code 5 (register indirect) uses the low 12 bits of the selected register as the effective address. It makes one read and gives `done` two cycles after start.
- R8: A `start` seen while `busy` is high is ignored. The request in flight completes with its own results and its own timing, and no extra `done` follows.
- R9: Mode codes 6 and 7 are reserved. They give `done` in the cycle after start, with `operand` 0, `ea` 0, `ea_valid` 0, and no memory read.
- R10: `operand`, `ea` and `ea_valid` hold their values between `done` pulses.
- R11: `busy` is high from the cycle after a memory-mode start up to the cycle before `done`. It is low whenever `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken only when not busy |
| mode | input | 3 | Addressing mode code |
| addr_field | input | 12 | Constant or address field of the instruction |
| reg_idx | input | 4 | Register number |
| rf_sel | output | 4 | Register-file read select |
| rf_data | input | 16 | Register-file read data (combinational) |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 12 | Memory read address |
| mem_rdata | input | 16 | Memory data, valid the cycle after a request |
| busy | output | 1 | A memory resolution is in flight |
| done | output | 1 | One-cycle completion strobe |
| ea | output | 12 | Effective address of the last completed request |
| ea_valid | output | 1 | Last completed request had an effective address |
| operand | output | 16 | Operand value of the last completed request |

## Verification
If the state machine took a wrong transition, the `done` latency would be off by at least one cycle, or two strobes would appear for one request. The bench counts latency from the start cycle, so either fault shows within three cycles. If the machine chained the pointer wrongly or lost it, `ea` and `operand` would disagree with the memory model at the `done` pulse. A pointer word is produced for each address tested, so a stale word would show in the results. A request accepted while busy would show as an early or extra `done`, or as results that belong to the second request.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_IMM  = 3'd0,
        MODE_DIR  = 3'd1,
        MODE_REG  = 3'd2,
        MODE_IND  = 3'd3,
        MODE_IDX  = 3'd4,
        MODE_RIND = 3'd5
    } ea_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRST = 2'd1,
        ST_CHAIN = 2'd2
    } ea_state_e;

endpackage

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
    import ea_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [ADDR_W-1:0] field,
    input  logic [DATA_W-1:0] reg_val,
    output logic [ADDR_W-1:0] first_addr,
    output logic              needs_mem,
    output logic              two_step,
    output logic [DATA_W-1:0] direct_val
);

    localparam int PAD_W = DATA_W - ADDR_W;

    logic [ADDR_W-1:0] reg_addr;
    assign reg_addr = reg_val[ADDR_W-1:0];

    always_comb begin
        first_addr = field;
        needs_mem  = 1'b0;
        two_step   = 1'b0;
        direct_val = '0;
        case (mode)
            MODE_IMM:  direct_val = {{PAD_W{1'b0}}, field};
            MODE_REG:  direct_val = reg_val;
            MODE_DIR:  needs_mem = 1'b1;
            MODE_IND: begin
                needs_mem = 1'b1;
                two_step  = 1'b1;
            end
            MODE_IDX: begin
                needs_mem  = 1'b1;
                first_addr = field + reg_addr;
            end
            MODE_RIND: begin
                needs_mem  = 1'b1;
                first_addr = reg_addr;
            end
            default: direct_val = '0;
        endcase
    end

endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
    import ea_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] first_addr,
    input  logic              needs_mem,
    input  logic              two_step,
    input  logic [DATA_W-1:0] direct_val,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] ea,
    output logic              ea_valid,
    output logic [DATA_W-1:0] operand
);

    ea_state_e         state, nxt;
    logic              chain_q;
    logic [ADDR_W-1:0] pend_ea;
    logic              accept;

    assign accept = start && (state == ST_IDLE);
    assign busy   = (state != ST_IDLE);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (accept && needs_mem) nxt = ST_FIRST;
            ST_FIRST: nxt = chain_q ? ST_CHAIN : ST_IDLE;
            ST_CHAIN: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        mem_rd   = 1'b0;
        mem_addr = first_addr;
        unique case (state)
            ST_IDLE:  mem_rd = accept && needs_mem;
            ST_FIRST: begin
                mem_rd   = chain_q;
                mem_addr = mem_rdata[ADDR_W-1:0];
            end
            ST_CHAIN: mem_rd = 1'b0;
            default:  mem_rd = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            ea       <= '0;
            ea_valid <= 1'b0;
            operand  <= '0;
            pend_ea  <= '0;
            chain_q  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (accept) begin
                    if (needs_mem) begin
                        pend_ea <= first_addr;
                        chain_q <= two_step;
                    end else begin
                        done     <= 1'b1;
                        ea       <= '0;
                        ea_valid <= 1'b0;
                        operand  <= direct_val;
                    end
                end
                ST_FIRST: begin
                    if (chain_q) begin
                        pend_ea <= mem_rdata[ADDR_W-1:0];
                    end else begin
                        done     <= 1'b1;
                        ea       <= pend_ea;
                        ea_valid <= 1'b1;
                        operand  <= mem_rdata;
                    end
                end
                ST_CHAIN: begin
                    done     <= 1'b1;
                    ea       <= pend_ea;
                    ea_valid <= 1'b1;
                    operand  <= mem_rdata;
                end
                default: done <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/ea_unit.sv
module ea_unit
    import ea_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 16,
    parameter int REG_COUNT = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [MODE_W-1:0]            mode,
    input  logic [ADDR_W-1:0]            addr_field,
    input  logic [$clog2(REG_COUNT)-1:0] reg_idx,
    output logic [$clog2(REG_COUNT)-1:0] rf_sel,
    input  logic [DATA_W-1:0]            rf_data,
    output logic                         mem_rd,
    output logic [ADDR_W-1:0]            mem_addr,
    input  logic [DATA_W-1:0]            mem_rdata,
    output logic                         busy,
    output logic                         done,
    output logic [ADDR_W-1:0]            ea,
    output logic                         ea_valid,
    output logic [DATA_W-1:0]            operand
);

    logic [ADDR_W-1:0] first_addr;
    logic              needs_mem;
    logic              two_step;
    logic [DATA_W-1:0] direct_val;

    assign rf_sel = reg_idx;

    ea_addr_calc #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_calc (
        .mode       (mode),
        .field      (addr_field),
        .reg_val    (rf_data),
        .first_addr (first_addr),
        .needs_mem  (needs_mem),
        .two_step   (two_step),
        .direct_val (direct_val)
    );

    ea_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .first_addr (first_addr),
        .needs_mem  (needs_mem),
        .two_step   (two_step),
        .direct_val (direct_val),
        .mem_rdata  (mem_rdata),
        .mem_rd     (mem_rd),
        .mem_addr   (mem_addr),
        .busy       (busy),
        .done       (done),
        .ea         (ea),
        .ea_valid   (ea_valid),
        .operand    (operand)
    );

endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk
    import ea_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 16,
    parameter int REG_COUNT = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         start,
    input logic [MODE_W-1:0]            mode,
    input logic [ADDR_W-1:0]            addr_field,
    input logic [$clog2(REG_COUNT)-1:0] reg_idx,
    input logic [$clog2(REG_COUNT)-1:0] rf_sel,
    input logic [DATA_W-1:0]            rf_data,
    input logic                         mem_rd,
    input logic [ADDR_W-1:0]            mem_addr,
    input logic [DATA_W-1:0]            mem_rdata,
    input logic                         busy,
    input logic                         done,
    input logic [ADDR_W-1:0]            ea,
    input logic                         ea_valid,
    input logic [DATA_W-1:0]            operand
);

    localparam int PAD_W = DATA_W - ADDR_W;

    // R2
    imm_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && mode == 3'd0) |=>
            (done && !ea_valid && operand == {{PAD_W{1'b0}}, $past(addr_field)}));

    // R3
    reg_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && mode == 3'd2) |=> (done && operand == $past(rf_data)));

    // R4
    dir_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && mode == 3'd1) |-> (mem_rd && mem_addr == addr_field));

    // R6
    idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && mode == 3'd4) |->
            (mem_rd && mem_addr == ADDR_W'(addr_field + rf_data[ADDR_W-1:0])));

    // R9
    rsv_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && mode[2:1] == 2'b11) |-> !mem_rd);

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(operand) && $stable(ea) && $stable(ea_valid)));

    // R11
    busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

bind ea_unit ea_unit_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_COUNT(REG_COUNT)
) i_ea_unit_chk (.*);

// File: tb/test_ea_unit.sv
module test_ea_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic [11:0] addr_field = '0;
    logic [3:0]  reg_idx = '0;
    logic [3:0]  rf_sel;
    logic [15:0] rf_data;
    logic        mem_rd;
    logic [11:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic        busy, done, ea_valid;
    logic [11:0] ea;
    logic [15:0] operand;

    logic [15:0] regs [16];
    logic [15:0] salt = 16'h5A3C;
    int          rd_cnt = 0;
    int          n_checks = 0;
    int          n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ea_unit i_ea_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .addr_field(addr_field), .reg_idx(reg_idx), .rf_sel(rf_sel),
        .rf_data(rf_data), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .ea(ea),
        .ea_valid(ea_valid), .operand(operand)
    );

    function automatic logic [15:0] mem_fn(input logic [11:0] a);
        logic [15:0] p;
        p = 16'({4'b0, a} * 16'h9E37);
        return p ^ salt ^ {a[3:0], 12'h000};
    endfunction

    assign rf_data = regs[rf_sel];

    always_ff @(posedge clk) begin
        if (mem_rd) begin
            mem_rdata <= mem_fn(mem_addr);
            rd_cnt    <= rd_cnt + 1;
        end
    end

    function automatic int exp_lat(input logic [2:0] m);
        case (m)
            3'd1, 3'd4, 3'd5: return 2;
            3'd3:             return 3;
            default:          return 1;
        endcase
    endfunction

    function automatic int exp_reads(input logic [2:0] m);
        case (m)
            3'd1, 3'd4, 3'd5: return 1;
            3'd3:             return 2;
            default:          return 0;
        endcase
    endfunction

    function automatic logic [11:0] exp_ea(input logic [2:0] m, input logic [11:0] f,
                                           input logic [3:0] r);
        case (m)
            3'd1:    return f;
            3'd3:    return mem_fn(f) & 16'h0FFF;
            3'd4:    return 12'(f + regs[r][11:0]);
            3'd5:    return regs[r][11:0];
            default: return 12'h000;
        endcase
    endfunction

    function automatic logic [15:0] exp_opnd(input logic [2:0] m, input logic [11:0] f,
                                             input logic [3:0] r);
        case (m)
            3'd0:             return {4'h0, f};
            3'd2:             return regs[r];
            3'd1, 3'd3, 3'd4,
            3'd5:             return mem_fn(exp_ea(m, f, r));
            default:          return 16'h0000;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] m);
        case (m)
            3'd0:    return "R2";
            3'd1:    return "R4";
            3'd2:    return "R3";
            3'd3:    return "R5";
            3'd4:    return "R6";
            3'd5:    return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic run_op(input logic [2:0] m, input logic [11:0] f, input logic [3:0] r);
        int lat;
        string t;
        logic [11:0] e_ea;
        logic [15:0] e_op;
        t    = tag_of(m);
        e_ea = exp_ea(m, f, r);
        e_op = exp_opnd(m, f, r);
        @(negedge clk);
        start = 1'b1; mode = m; addr_field = f; reg_idx = r; rd_cnt = 0;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        if (exp_lat(m) > 1) chk(busy === 1'b1, "R11 busy after start", 32'(busy), 1);
        while (done !== 1'b1 && lat < 12) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == exp_lat(m), {t, " latency"}, lat, exp_lat(m));
        chk(operand === e_op, {t, " operand"}, operand, e_op);
        chk(ea === e_ea, {t, " ea"}, ea, e_ea);
        chk(ea_valid === (exp_reads(m) > 0), {t, " ea_valid"}, ea_valid, exp_reads(m) > 0);
        chk(rd_cnt == exp_reads(m), {t, " read count"}, rd_cnt, exp_reads(m));
        chk(busy === 1'b0, "R11 busy low at done", 32'(busy), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) regs[i] = 16'($urandom);
        regs[3] = 16'hF001;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(done === 1'b0, "R1 done", 32'(done), 0);
        chk(busy === 1'b0, "R1 busy", 32'(busy), 0);
        chk(ea_valid === 1'b0, "R1 ea_valid", 32'(ea_valid), 0);
        chk(operand === 16'h0, "R1 operand", operand, 0);
        chk(ea === 12'h0, "R1 ea", ea, 0);

        // directed corners
        run_op(3'd0, 12'hFFF, 4'd0);      // R2 full-width constant
        run_op(3'd2, 12'h000, 4'd3);      // R3
        run_op(3'd1, 12'hABC, 4'd0);      // R4
        run_op(3'd3, 12'h123, 4'd0);      // R5
        run_op(3'd4, 12'hFFF, 4'd3);      // R6 wrap: FFF + 001 -> 000
        chk(ea === 12'h000, "R6 wrap to zero", ea, 0);
        run_op(3'd5, 12'h000, 4'd3);      // R7 uses low 12 bits only
        run_op(3'd6, 12'h777, 4'd1);      // R9
        run_op(3'd7, 12'h777, 4'd1);      // R9

        // R8 start while busy is ignored
        begin
            int lat;
            int extra;
            logic [15:0] e_op;
            e_op = mem_fn(12'h456);
            @(negedge clk);
            start = 1'b1; mode = 3'd1; addr_field = 12'h456; reg_idx = 4'd0; rd_cnt = 0;
            @(negedge clk);
            mode = 3'd0; addr_field = 12'h999;
            lat = 1;
            @(negedge clk);
            start = 1'b0;
            lat++;
            chk(lat == 2 && done === 1'b1, "R8 latency of first request", lat, 2);
            chk(operand === e_op, "R8 operand of first request", operand, e_op);
            chk(rd_cnt == 1, "R8 read count", rd_cnt, 1);
            extra = 0;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                if (done === 1'b1) extra++;
                addr_field = 12'(k);
                mode = 3'(k);
            end
            chk(extra == 0, "R8 no extra done", extra, 0);
            // R10 results held between done pulses
            chk(operand === e_op, "R10 operand held", operand, e_op);
            chk(ea === 12'h456, "R10 ea held", ea, 12'h456);
        end

        // constrained random
        for (int n = 0; n < 300; n++) begin
            logic [2:0] m;
            if (n % 25 == 0) begin
                salt = 16'($urandom);
                for (int i = 0; i < 16; i++) regs[i] = 16'($urandom);
            end
            m = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 9) < 8) m = 3'($urandom_range(0, 5));
            run_op(m, 12'($urandom), 4'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule